// File: doc/BRIEF.md
# Load Effective Address Generator

This block resolves one load operand. It takes an already-decoded addressing mode, a 12-bit immediate field, the values of a base and an index register, and the current program counter. It forms the operand's address, or the operand itself for the constant mode, reads memory through a synchronous read port with one cycle of latency, and returns the loaded word together with a one-cycle completion pulse.

Three offset flavours share the base-plus-immediate arithmetic. They differ only in which address goes to memory and whether the base register is updated. The pointer-chasing mode issues two dependent reads inside a single operation: the first fetches a pointer, and the second fetches the operand that pointer names. The register file is outside the block. When an update applies, the block presents a new base value and an enable, and the register file performs the write.

Top module: `lea_unit`

## Requirements
- R1: Mode code 0 (constant) returns the 12-bit immediate sign-extended to 32 bits as the result. It never raises mem_re.
- R2: Mode code 1 (absolute) reads memory at the immediate zero-extended to 32 bits.
- R3: Mode code 2 (register pointer) reads memory at base_val.
- R4: Mode code 3 (offset, no update) reads at base_val plus the sign-extended immediate and leaves wb_en low.
- R5: Mode code 4 (offset with update) reads at base_val plus the sign-extended immediate. With done it pulses wb_en, and wb_addr carries that same sum.
- R6: Mode code 5 (update after use) reads at the unmodified base_val. With done it pulses wb_en, and wb_addr carries base_val plus the sign-extended immediate.
- R7: Mode code 6 (program-relative) reads at pc_val plus the sign-extended immediate.
- R8: Mode code 7 (indexed) reads at base_val plus index_val.
- R9: Mode code 8 (double indirection) first reads a pointer at base_val, then reads at the returned pointer. done rises three cycles after the accepted start.
- R10: For every mode other than 8, done is a one-cycle pulse two cycles after the accepted start. result is valid with done and holds until the next completion.
- R11: wb_en is high only in a done cycle, and only for mode codes 4 and 5.
- R12: A start raised while an operation is in flight is ignored. It causes no extra completion and does not alter the running operation's result.
- R13: Mode codes 9 to 15 complete with a zero result, without wb_en and without any memory read.
- R14: All address sums wrap modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| mode | input | 4 | Addressing mode code |
| imm | input | 12 | Immediate / offset / absolute address field |
| base_val | input | 32 | Base register value |
| index_val | input | 32 | Index register value |
| pc_val | input | 32 | Program counter value |
| mem_re | output | 1 | Memory read request |
| mem_addr | output | 32 | Memory read address |
| mem_rdata | input | 32 | Read data, valid the cycle after a request |
| result | output | 32 | Loaded operand |
| wb_addr | output | 32 | Updated base register value |
| wb_en | output | 1 | Base register update strobe |
| done | output | 1 | Completion pulse |

## Verification
The bench builds the block with its default widths: a 32-bit datapath and a 12-bit immediate. At these widths an immediate of 0x800 gives the most negative offset and 0x7FF the most positive. A base near 0xFFFFFFFF carries the sum past the top of the address space, so sign extension and modulo-2^32 wrap are both exercised directly. The memory model returns a word computed from the low address byte. That makes each expected operand, including the pointer that double indirection follows, independent of the design under test.

// File: rtl/lea_pkg.sv
package lea_pkg;

    localparam int MODE_W = 4;

    typedef enum logic [MODE_W-1:0] {
        M_CONST   = 4'd0,
        M_ABS     = 4'd1,
        M_REGPTR  = 4'd2,
        M_OFS     = 4'd3,
        M_OFS_UPD = 4'd4,
        M_POST    = 4'd5,
        M_PCREL   = 4'd6,
        M_INDEX   = 4'd7,
        M_DBLIND  = 4'd8
    } mode_e;

    // Operand that supplies the left side of the adder
    typedef enum logic [1:0] {
        LHS_ZERO = 2'd0,
        LHS_BASE = 2'd1,
        LHS_PC   = 2'd2
    } lhs_e;

    // Operand that supplies the right side of the adder
    typedef enum logic [1:0] {
        RHS_NONE = 2'd0,
        RHS_SOFS = 2'd1,
        RHS_ZIMM = 2'd2,
        RHS_IDX  = 2'd3
    } rhs_e;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_ISSUE = 2'd1,
        S_PTR   = 2'd2,
        S_LAST  = 2'd3
    } seq_e;

    typedef struct packed {
        logic known;     // mode code is defined
        logic use_mem;   // operand comes from memory
        logic chase;     // two dependent reads
        logic upd;       // base register update
        logic post;      // access with unmodified base
        lhs_e lhs;
        rhs_e rhs;
    } ctl_t;

    function automatic ctl_t decode_mode(input logic [MODE_W-1:0] code);
        ctl_t c;
        c = '{known: 1'b1, use_mem: 1'b1, chase: 1'b0, upd: 1'b0,
              post: 1'b0, lhs: LHS_BASE, rhs: RHS_NONE};
        case (code)
            M_CONST:   begin c.use_mem = 1'b0; c.lhs = LHS_ZERO; c.rhs = RHS_SOFS; end
            M_ABS:     begin c.lhs = LHS_ZERO; c.rhs = RHS_ZIMM; end
            M_REGPTR:  begin c.rhs = RHS_NONE; end
            M_OFS:     begin c.rhs = RHS_SOFS; end
            M_OFS_UPD: begin c.rhs = RHS_SOFS; c.upd = 1'b1; end
            M_POST:    begin c.rhs = RHS_SOFS; c.upd = 1'b1; c.post = 1'b1; end
            M_PCREL:   begin c.lhs = LHS_PC; c.rhs = RHS_SOFS; end
            M_INDEX:   begin c.rhs = RHS_IDX; end
            M_DBLIND:  begin c.chase = 1'b1; end
            default:   begin
                c.known = 1'b0; c.use_mem = 1'b0; c.lhs = LHS_ZERO;
            end
        endcase
        return c;
    endfunction

endpackage

// File: rtl/lea_decode.sv
module lea_decode
    import lea_pkg::*;
(
    input  logic [MODE_W-1:0] mode,
    output ctl_t              ctl
);
    always_comb begin
        ctl = decode_mode(mode);
    end
endmodule

// File: rtl/lea_agen.sv
module lea_agen
    import lea_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 12
) (
    input  ctl_t              ctl,
    input  logic [IMM_W-1:0]  imm,
    input  logic [DATA_W-1:0] base_val,
    input  logic [DATA_W-1:0] index_val,
    input  logic [DATA_W-1:0] pc_val,
    output logic [DATA_W-1:0] acc_addr,
    output logic [DATA_W-1:0] upd_val,
    output logic [DATA_W-1:0] const_val
);
    localparam int EXT_W = DATA_W - IMM_W;

    logic [DATA_W-1:0] sofs, zimm, lhs_v, rhs_v, sum;

    assign sofs = {{EXT_W{imm[IMM_W-1]}}, imm};
    assign zimm = {{EXT_W{1'b0}}, imm};

    always_comb begin
        case (ctl.lhs)
            LHS_BASE: lhs_v = base_val;
            LHS_PC:   lhs_v = pc_val;
            default:  lhs_v = '0;
        endcase
        case (ctl.rhs)
            RHS_SOFS: rhs_v = sofs;
            RHS_ZIMM: rhs_v = zimm;
            RHS_IDX:  rhs_v = index_val;
            default:  rhs_v = '0;
        endcase
    end

    // Sum truncates to DATA_W bits: modulo 2^DATA_W wrap
    assign sum       = lhs_v + rhs_v;
    assign acc_addr  = ctl.post ? lhs_v : sum;
    assign upd_val   = sum;
    assign const_val = sum;
endmodule

// File: rtl/lea_seq.sv
module lea_seq
    import lea_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  ctl_t              ctl,
    input  logic [DATA_W-1:0] acc_addr,
    input  logic [DATA_W-1:0] upd_val,
    input  logic [DATA_W-1:0] const_val,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_re,
    output logic [DATA_W-1:0] mem_addr,
    output logic [DATA_W-1:0] result,
    output logic [DATA_W-1:0] wb_addr,
    output logic              wb_en,
    output logic              done,
    output logic              busy
);
    seq_e              state;
    ctl_t              ctl_q;
    logic [DATA_W-1:0] addr_q, upd_q, const_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= S_IDLE;
            ctl_q   <= '0;
            addr_q  <= '0;
            upd_q   <= '0;
            const_q <= '0;
            result  <= '0;
            wb_addr <= '0;
            wb_en   <= 1'b0;
            done    <= 1'b0;
        end else begin
            done  <= 1'b0;
            wb_en <= 1'b0;
            case (state)
                S_IDLE: begin
                    if (start) begin
                        ctl_q   <= ctl;
                        addr_q  <= acc_addr;
                        upd_q   <= upd_val;
                        const_q <= const_val;
                        state   <= S_ISSUE;
                    end
                end
                S_ISSUE: state <= ctl_q.chase ? S_PTR : S_LAST;
                S_PTR:   state <= S_LAST;
                S_LAST: begin
                    if (!ctl_q.known)
                        result <= '0;
                    else if (ctl_q.use_mem)
                        result <= mem_rdata;
                    else
                        result <= const_q;
                    wb_en   <= ctl_q.known & ctl_q.upd;
                    wb_addr <= upd_q;
                    done    <= 1'b1;
                    state   <= S_IDLE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // Second read of a chase is addressed by the word just returned
    assign mem_re   = (state == S_ISSUE && ctl_q.use_mem) || (state == S_PTR);
    assign mem_addr = (state == S_PTR) ? mem_rdata : addr_q;
    assign busy     = (state != S_IDLE);
endmodule

// File: rtl/lea_unit.sv
module lea_unit
    import lea_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [MODE_W-1:0] mode,
    input  logic [IMM_W-1:0]  imm,
    input  logic [DATA_W-1:0] base_val,
    input  logic [DATA_W-1:0] index_val,
    input  logic [DATA_W-1:0] pc_val,
    output logic              mem_re,
    output logic [DATA_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] result,
    output logic [DATA_W-1:0] wb_addr,
    output logic              wb_en,
    output logic              done
);
    ctl_t              ctl;
    logic [DATA_W-1:0] acc_addr, upd_val, const_val;
    logic              busy;

    lea_decode u_dec (
        .mode (mode),
        .ctl  (ctl)
    );

    lea_agen #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_agen (
        .ctl       (ctl),
        .imm       (imm),
        .base_val  (base_val),
        .index_val (index_val),
        .pc_val    (pc_val),
        .acc_addr  (acc_addr),
        .upd_val   (upd_val),
        .const_val (const_val)
    );

    lea_seq #(.DATA_W(DATA_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .ctl       (ctl),
        .acc_addr  (acc_addr),
        .upd_val   (upd_val),
        .const_val (const_val),
        .mem_rdata (mem_rdata),
        .mem_re    (mem_re),
        .mem_addr  (mem_addr),
        .result    (result),
        .wb_addr   (wb_addr),
        .wb_en     (wb_en),
        .done      (done),
        .busy      (busy)
    );
endmodule

// File: rtl/lea_unit_chk.sv
module lea_unit_chk
    import lea_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic [MODE_W-1:0] mode,
    input logic              busy,
    input logic              mem_re,
    input logic [DATA_W-1:0] result,
    input logic              wb_en,
    input logic              done
);
    logic accept;
    assign accept = start && !busy;

    // R1: constant mode issues no read in its issue cycle
    a_r1_const_no_read: assert property (@(posedge clk) disable iff (rst)
        (accept && mode == M_CONST) |=> !mem_re);

    // R9: double indirection completes three cycles after acceptance
    a_r9_chase_latency: assert property (@(posedge clk) disable iff (rst)
        (accept && mode == M_DBLIND) |-> ##4 done);

    // R10: single-read modes complete two cycles after acceptance
    a_r10_single_latency: assert property (@(posedge clk) disable iff (rst)
        (accept && mode != M_DBLIND) |-> ##3 done);

    // R10: completion is a one-cycle pulse
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R11: update strobe only accompanies completion
    a_r11_wb_with_done: assert property (@(posedge clk) disable iff (rst)
        wb_en |-> done);

    // R13: undefined codes finish with zero and no update
    a_r13_undef_zero: assert property (@(posedge clk) disable iff (rst)
        (accept && mode > M_DBLIND) |-> ##3 (done && result == '0 && !wb_en));

    // R13: no read request outside an operation
    a_r13_read_only_busy: assert property (@(posedge clk) disable iff (rst)
        mem_re |-> busy);
endmodule

bind lea_unit lea_unit_chk #(.DATA_W(DATA_W)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .mode   (mode),
    .busy   (busy),
    .mem_re (mem_re),
    .result (result),
    .wb_en  (wb_en),
    .done   (done)
);

// File: tb/tb_lea_unit.sv
module tb_lea_unit;
    localparam int DW = 32;
    localparam int IW = 12;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [3:0]    mode = '0;
    logic [IW-1:0] imm = '0;
    logic [DW-1:0] base_val = '0, index_val = '0, pc_val = '0;
    logic          mem_re;
    logic [DW-1:0] mem_addr, mem_rdata, result, wb_addr;
    logic          wb_en, done;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;   // 50 MHz

    lea_unit #(.DATA_W(DW), .IMM_W(IW)) dut (
        .clk(clk), .rst(rst), .start(start), .mode(mode), .imm(imm),
        .base_val(base_val), .index_val(index_val), .pc_val(pc_val),
        .mem_re(mem_re), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .result(result), .wb_addr(wb_addr), .wb_en(wb_en), .done(done)
    );

    // Memory model: contents computed from the low address byte
    function automatic logic [DW-1:0] memf(input logic [7:0] a);
        return {a ^ 8'hC3, a, ~a, a + 8'h11};
    endfunction

    always_ff @(posedge clk) begin
        if (rst) mem_rdata <= '0;
        else if (mem_re) mem_rdata <= memf(mem_addr[7:0]);
    end

    function automatic logic [DW-1:0] sx(input logic [IW-1:0] v);
        return {{(DW-IW){v[IW-1]}}, v};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One operation: drive, then check each cycle up to and after done
    task automatic run_op(input string tag, input logic [3:0] m, input logic [IW-1:0] im,
                          input logic [DW-1:0] b, input logic [DW-1:0] x,
                          input logic [DW-1:0] p, input bit uses_mem, input bit chase,
                          input logic [DW-1:0] exp_addr, input logic [DW-1:0] exp_res,
                          input bit exp_wb, input logic [DW-1:0] exp_wbv);
        @(negedge clk);
        mode = m; imm = im; base_val = b; index_val = x; pc_val = p; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (uses_mem)
            chk(mem_re === 1'b1 && mem_addr === exp_addr, {tag, " addr"}, mem_addr, exp_addr);
        else
            chk(mem_re === 1'b0, {tag, " no read"}, {31'd0, mem_re}, '0);
        chk(done === 1'b0, {tag, " early done"}, {31'd0, done}, '0);
        @(negedge clk);
        if (chase) begin
            chk(mem_re === 1'b1 && mem_addr === memf(exp_addr[7:0]), {tag, " ptr addr"},
                mem_addr, memf(exp_addr[7:0]));
            @(negedge clk);
        end
        chk(done === 1'b0 && mem_re === 1'b0, {tag, " wait"}, {30'd0, done, mem_re}, '0);
        @(negedge clk);
        chk(done === 1'b1, {tag, " done timing"}, {31'd0, done}, 1);
        chk(result === exp_res, {tag, " result"}, result, exp_res);
        chk(wb_en === exp_wb, {tag, " wb_en"}, {31'd0, wb_en}, {31'd0, exp_wb});
        if (exp_wb) chk(wb_addr === exp_wbv, {tag, " wb_addr"}, wb_addr, exp_wbv);
        @(negedge clk);
        chk(done === 1'b0 && wb_en === 1'b0 && result === exp_res, {tag, " pulse/hold"},
            result, exp_res);
    endtask

    task automatic t_reset();
        chk(done === 0 && wb_en === 0 && mem_re === 0 && result === 0, "R10 reset state",
            result, '0);
    endtask

    task automatic t_const();
        run_op("R1 const neg", 4'd0, 12'h800, 32'h1234, 0, 0, 0, 0, 0, 32'hFFFF_F800, 0, 0);
        run_op("R1 const pos", 4'd0, 12'h7FF, 32'h1234, 0, 0, 0, 0, 0, 32'h0000_07FF, 0, 0);
    endtask

    task automatic t_abs();
        run_op("R2 absolute", 4'd1, 12'hABC, 32'h5000, 0, 0, 1, 0, 32'h0000_0ABC,
               memf(8'hBC), 0, 0);
    endtask

    task automatic t_regptr();
        run_op("R3 regptr", 4'd2, 12'h044, 32'h0000_2057, 0, 0, 1, 0, 32'h0000_2057,
               memf(8'h57), 0, 0);
    endtask

    task automatic t_ofs();
        run_op("R4 offset", 4'd3, 12'hFFF, 32'h0000_0100, 0, 0, 1, 0, 32'h0000_00FF,
               memf(8'hFF), 0, 0);
    endtask

    task automatic t_ofs_upd();
        run_op("R5 offset update", 4'd4, 12'h010, 32'h0000_0420, 0, 0, 1, 0, 32'h0000_0430,
               memf(8'h30), 1, 32'h0000_0430);
    endtask

    task automatic t_post();
        run_op("R6 post update", 4'd5, 12'hFF8, 32'h0000_0640, 0, 0, 1, 0, 32'h0000_0640,
               memf(8'h40), 1, 32'h0000_0638);
    endtask

    task automatic t_pcrel();
        run_op("R7 pc relative", 4'd6, 12'h800, 0, 0, 32'h0000_0040, 1, 0, 32'hFFFF_F840,
               memf(8'h40), 0, 0);
    endtask

    task automatic t_index();
        run_op("R8 indexed", 4'd7, 12'h123, 32'h0000_1000, 32'h0000_0077, 0, 1, 0,
               32'h0000_1077, memf(8'h77), 0, 0);
    endtask

    task automatic t_chase();
        // pointer = memf(0x10); its low byte 0x21 names the operand
        run_op("R9 double indirect", 4'd8, 12'h000, 32'h0000_0010, 0, 0, 1, 1, 32'h0000_0010,
               memf(memf(8'h10)[7:0]), 0, 0);
    endtask

    task automatic t_wrap();
        run_op("R14 wrap", 4'd4, 12'h020, 32'hFFFF_FFF0, 0, 0, 1, 0, 32'h0000_0010,
               memf(8'h10), 1, 32'h0000_0010);
    endtask

    task automatic t_undef();
        for (int c = 9; c < 16; c += 3)
            run_op("R13 undefined", c[3:0], 12'h555, 32'h0000_0300, 32'h5, 32'h9, 0, 0, 0,
                   0, 0, 0);
    endtask

    task automatic t_busy();
        logic [DW-1:0] exp;
        exp = memf(memf(8'h33)[7:0]);
        @(negedge clk);
        mode = 4'd8; imm = '0; base_val = 32'h33; start = 1'b1;
        @(negedge clk);
        mode = 4'd0; imm = 12'h00F;                 // stray start while busy
        @(negedge clk);
        chk(done === 1'b0, "R12 no early done", {31'd0, done}, '0);
        start = 1'b0;
        @(negedge clk);
        chk(done === 1'b0, "R12 still running", {31'd0, done}, '0);
        @(negedge clk);
        chk(done === 1'b1 && result === exp, "R12 busy start ignored", result, exp);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(done === 1'b0 && result === exp, "R12 no extra completion", result, exp);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_const();
        t_abs();
        t_regptr();
        t_ofs();
        t_ofs_upd();
        t_post();
        t_pcrel();
        t_index();
        t_chase();
        t_wrap();
        t_undef();
        t_busy();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule